// File: doc/BRIEF.md
# Shadow Instruction Prefetch Queue

This block keeps a three-stage copy of a processor's instruction prefetch queue outside the processor. From that copy, trace or debug logic can tell which opcode is executing at any moment. The stages are called A (newest), B and C (oldest). Each stage holds a word and has its own validity bit. Instruction-fetch words seen on a monitored bus enter stage A. A word then falls through on its own into any later stage that is empty, moving one stage per clock.

A separate pipeline-status decoder issues the advance commands. A partial advance consumes the word in B as an extension word. A full advance moves B into C and A into B together, which starts a new instruction whose opcode is the word loaded into C. Commands keep arriving when no fetches happen (the processor may be recirculating words internally), so the queue advances on commands alone. A resync request from the decoder empties the queue. A sticky error flag records advances commanded from an empty stage and fetch words that found stage A still occupied.

Top module: `shadow_pfq`

## Requirements
- R1: After a synchronous reset, every validity bit (stage_valid_o bit 0 = A, bit 1 = B, bit 2 = C) is clear, both strobes are low and err_o is low.
- R2: A fetch word is captured into stage A at the edge where fetch_valid_i is high, provided that A is empty after that cycle's transfers. A word does not pass stage A in the cycle it arrives.
- R3: With no command pending, a valid word moves into the next stage whenever that stage is empty or is being emptied in the same cycle, one stage per clock. A load of C by fall-through pulses insn_start_o.
- R4: A partial advance with B valid pulses ext_used_o for one cycle, with ext_word_o set to the word that was in B. B then takes A's word if A was valid and otherwise becomes invalid, and A becomes invalid.
- R5: A full advance with B valid loads B's word into C and A's word into B in the same edge. It pulses insn_start_o, and opcode_o shows the new C word.
- R6: When both advance commands are high in the same cycle, only the full advance takes effect and ext_used_o stays low.
- R7: A commanded advance takes precedence over fall-through. A partial advance while C is empty does not move B into C and does not pulse insn_start_o.
- R8: An advance commanded while B is invalid sets err_o. A full advance in that case leaves C invalid and pulses no strobe.
- R9: A fetch word arriving while stage A stays occupied is dropped and sets err_o.
- R10: A resync request clears all three validity bits at the next edge, pulses no strobe and leaves err_o unchanged.
- R11: Once set, err_o stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| fetch_valid_i | input | 1 | Instruction-fetch word present on the monitored bus |
| fetch_word_i | input | WORD_W | Fetched instruction word |
| adv_part_i | input | 1 | Partial-advance command (extension word consumed) |
| adv_full_i | input | 1 | Full-advance command (new instruction started) |
| resync_i | input | 1 | Decoder resync request: empty the queue |
| stage_valid_o | output | 3 | Validity bits: bit 0 A, bit 1 B, bit 2 C |
| opcode_o | output | WORD_W | Word held in stage C |
| insn_start_o | output | 1 | One-cycle pulse: C was loaded with a new opcode |
| ext_used_o | output | 1 | One-cycle pulse: extension word consumed from B |
| ext_word_o | output | WORD_W | Extension word consumed by the last partial advance |
| err_o | output | 1 | Sticky error flag |

## Verification
The hardest state to reach is a full queue in which a fall-through into C and a fall-through into B happen on the same edge while a new fetch lands in A. That requires three back-to-back fetch words starting from an empty queue. The bench builds this state directly and then reaches the overrun case with one more fetch. It also checks that the dropped word never appears: two partial advances follow, and their consumed extension words show the dropped word was never stored. The command-only stretch of the table drains the queue through partial and full advances with no fetches.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int NSTAGE = 3;
    localparam int ST_A   = 0;
    localparam int ST_B   = 1;
    localparam int ST_C   = 2;

    typedef struct packed {
        logic [NSTAGE-1:0] valid;
        logic              start;
        logic              ext;
        logic              err;
    } sq_ctl_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
    import sq_pkg::*;
(
    input  logic [NSTAGE-1:0] valid_q,
    input  logic              fetch,
    input  logic              part_cmd,
    input  logic              full_cmd,
    input  logic              resync,
    output logic [NSTAGE-1:0] load,
    output logic [NSTAGE-1:0] valid_d,
    output logic              start_d,
    output logic              ext_d,
    output logic              err_set
);
    logic full, part, cmd;
    logic va, vb, vc;
    logic bc_move, ab_move, a_keep, take;

    always_comb begin
        full    = full_cmd;
        part    = part_cmd & ~full_cmd;
        cmd     = full | part;
        va      = valid_q[ST_A];
        vb      = valid_q[ST_B];
        vc      = valid_q[ST_C];

        // B to C: commanded full advance, or fall-through when C is empty
        bc_move = vb & (full | (~part & ~vc));
        // A to B: any command, or fall-through when B is empty or emptying
        ab_move = va & (cmd | ~vb | bc_move);
        a_keep  = va & ~ab_move;
        take    = fetch & ~a_keep;

        valid_d[ST_C] = full ? vb : (vc | bc_move);
        valid_d[ST_B] = cmd ? va : (ab_move | (vb & ~bc_move));
        valid_d[ST_A] = a_keep | take;

        load[ST_A] = take;
        load[ST_B] = ab_move;
        load[ST_C] = bc_move;

        start_d = bc_move;
        ext_d   = part & vb;
        err_set = (cmd & ~vb) | (fetch & a_keep);

        if (resync) begin
            valid_d = '0;
            load    = '0;
            start_d = 1'b0;
            ext_d   = 1'b0;
            err_set = 1'b0;
        end
    end
endmodule

// File: rtl/sq_stage.sv
module sq_stage #(
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en,
    input  logic [WORD_W-1:0] src,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-1:0] word_d;

    always_comb begin
        word_d = word_q;
        if (en) word_d = src;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) word_q <= '0;
        else       word_q <= word_d;
    end
endmodule

// File: rtl/shadow_pfq.sv
module shadow_pfq
    import sq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fetch_valid_i,
    input  logic [WORD_W-1:0] fetch_word_i,
    input  logic              adv_part_i,
    input  logic              adv_full_i,
    input  logic              resync_i,
    output logic [2:0]        stage_valid_o,
    output logic [WORD_W-1:0] opcode_o,
    output logic              insn_start_o,
    output logic              ext_used_o,
    output logic [WORD_W-1:0] ext_word_o,
    output logic              err_o
);
    sq_ctl_t           ctl_d, ctl_q;
    logic [WORD_W-1:0] ext_word_d, ext_word_q;
    logic [NSTAGE-1:0] load, valid_n;
    logic              start_n, ext_n, err_set;
    logic [WORD_W-1:0] word_q [NSTAGE];

    sq_ctrl u_ctrl (
        .valid_q  (ctl_q.valid),
        .fetch    (fetch_valid_i),
        .part_cmd (adv_part_i),
        .full_cmd (adv_full_i),
        .resync   (resync_i),
        .load     (load),
        .valid_d  (valid_n),
        .start_d  (start_n),
        .ext_d    (ext_n),
        .err_set  (err_set)
    );

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        logic [WORD_W-1:0] src;
        if (i == 0) begin : g_head
            assign src = fetch_word_i;
        end else begin : g_tail
            assign src = word_q[i-1];
        end
        sq_stage #(.WORD_W(WORD_W)) u_stage (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .en     (load[i]),
            .src    (src),
            .word_q (word_q[i])
        );
    end

    always_comb begin
        ctl_d.valid = valid_n;
        ctl_d.start = start_n;
        ctl_d.ext   = ext_n;
        ctl_d.err   = ctl_q.err | err_set;
        ext_word_d  = ext_word_q;
        if (ext_n) ext_word_d = word_q[ST_B];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q      <= '0;
            ext_word_q <= '0;
        end else begin
            ctl_q      <= ctl_d;
            ext_word_q <= ext_word_d;
        end
    end

    assign stage_valid_o = ctl_q.valid;
    assign opcode_o      = word_q[ST_C];
    assign insn_start_o  = ctl_q.start;
    assign ext_used_o    = ctl_q.ext;
    assign ext_word_o    = ext_word_q;
    assign err_o         = ctl_q.err;

    p_start_has_c_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        insn_start_o |-> stage_valid_o[ST_C]);
    p_ext_word_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_part_i && !adv_full_i && !resync_i && stage_valid_o[ST_B])
        |=> (ext_used_o && ext_word_o == $past(word_q[ST_B])));
    p_full_wins_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !(insn_start_o && ext_used_o));
    p_bad_full_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_full_i && !resync_i && !stage_valid_o[ST_B])
        |=> (err_o && !stage_valid_o[ST_C] && !insn_start_o));
    p_resync_clear_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        resync_i |=> (stage_valid_o == 3'b000));
    p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |=> err_o);
endmodule

// File: tb/shadow_pfq_bench.sv
module shadow_pfq_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         fetch_valid;
    logic [W-1:0] fetch_word;
    logic         adv_part, adv_full, resync;
    logic [2:0]   stage_valid;
    logic [W-1:0] opcode, ext_word;
    logic         insn_start, ext_used, err;
    int           checks = 0;
    int           errors = 0;

    always #4 clk = ~clk;

    shadow_pfq #(.WORD_W(W)) u_shadow_pfq (
        .clk_i         (clk),
        .rst_i         (rst),
        .fetch_valid_i (fetch_valid),
        .fetch_word_i  (fetch_word),
        .adv_part_i    (adv_part),
        .adv_full_i    (adv_full),
        .resync_i      (resync),
        .stage_valid_o (stage_valid),
        .opcode_o      (opcode),
        .insn_start_o  (insn_start),
        .ext_used_o    (ext_used),
        .ext_word_o    (ext_word),
        .err_o         (err)
    );

    typedef struct packed {
        logic         fv;
        logic [W-1:0] fw;
        logic         part;
        logic         full;
        logic         rs;
        logic [2:0]   ev;
        logic         est;
        logic [W-1:0] eop;
        logic         eext;
        logic [W-1:0] eew;
        logic         eerr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 16'h1111, 1'b0, 1'b0, 1'b0, 3'b001, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R2
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b010, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R3
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b100, 1'b1, 16'h1111, 1'b0, 16'h0000, 1'b0}, // R3
        '{1'b1, 16'h2222, 1'b0, 1'b0, 1'b0, 3'b101, 1'b0, 16'h1111, 1'b0, 16'h0000, 1'b0}, // R2
        '{1'b1, 16'h3333, 1'b0, 1'b0, 1'b0, 3'b111, 1'b0, 16'h1111, 1'b0, 16'h0000, 1'b0}, // R3
        '{1'b1, 16'h4444, 1'b1, 1'b0, 1'b0, 3'b111, 1'b0, 16'h1111, 1'b1, 16'h2222, 1'b0}, // R4
        '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 3'b110, 1'b1, 16'h3333, 1'b0, 16'h0000, 1'b0}, // R5
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 3'b100, 1'b0, 16'h3333, 1'b1, 16'h4444, 1'b0}, // R4
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 3'b100, 1'b0, 16'h3333, 1'b0, 16'h0000, 1'b1}, // R8
        '{1'b1, 16'h5555, 1'b0, 1'b1, 1'b0, 3'b001, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1}  // R8
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic f, input logic [W-1:0] w,
                         input logic p, input logic fu, input logic rs);
        fetch_valid = f;
        fetch_word  = w;
        adv_part    = p;
        adv_full    = fu;
        resync      = rs;
        @(negedge clk);
        fetch_valid = 1'b0;
        adv_part    = 1'b0;
        adv_full    = 1'b0;
        resync      = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        fetch_valid = 1'b0;
        fetch_word  = '0;
        adv_part    = 1'b0;
        adv_full    = 1'b0;
        resync      = 1'b0;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 valid", 32'(stage_valid), 32'h0);
        chk("R1 strobes", 32'({insn_start, ext_used}), 32'h0);
        chk("R1 err", 32'(err), 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(TABLE[i].fv, TABLE[i].fw, TABLE[i].part, TABLE[i].full, TABLE[i].rs);
            chk($sformatf("table row %0d valid", i), 32'(stage_valid), 32'(TABLE[i].ev));
            chk($sformatf("table row %0d start", i), 32'(insn_start), 32'(TABLE[i].est));
            chk($sformatf("table row %0d ext", i), 32'(ext_used), 32'(TABLE[i].eext));
            chk($sformatf("table row %0d err", i), 32'(err), 32'(TABLE[i].eerr));
            if (TABLE[i].ev[2])
                chk($sformatf("table row %0d opcode", i), 32'(opcode), 32'(TABLE[i].eop));
            if (TABLE[i].eext)
                chk($sformatf("table row %0d ext word", i), 32'(ext_word), 32'(TABLE[i].eew));
        end

        // R3 double fall-through with fetch, then R9 overrun
        do_reset();
        drive(1'b1, 16'h00A1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 16'h00A2, 1'b0, 1'b0, 1'b0);
        chk("R3 two stages filled", 32'(stage_valid), 32'h3);
        drive(1'b1, 16'h00A3, 1'b0, 1'b0, 1'b0);
        chk("R3 full queue", 32'(stage_valid), 32'h7);
        chk("R3 start on fall-through", 32'(insn_start), 32'h1);
        chk("R3 opcode", 32'(opcode), 32'h00A1);
        drive(1'b1, 16'h00A4, 1'b0, 1'b0, 1'b0);
        chk("R9 overrun err", 32'(err), 32'h1);
        chk("R9 valid unchanged", 32'(stage_valid), 32'h7);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        chk("R9 ext word A2", 32'(ext_word), 32'h00A2);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        chk("R9 ext word A3 (A4 dropped)", 32'(ext_word), 32'h00A3);
        chk("R9 B empty after drain", 32'(stage_valid), 32'h4);
        // R10 resync keeps err, R11 sticky
        drive(1'b0, '0, 1'b0, 1'b0, 1'b1);
        chk("R10 resync clears", 32'(stage_valid), 32'h0);
        chk("R11 err kept", 32'(err), 32'h1);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        chk("R11 err still high", 32'(err), 32'h1);

        // R6 full wins over partial
        do_reset();
        drive(1'b1, 16'h00B1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 16'h00B2, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 16'h00B3, 1'b0, 1'b0, 1'b0);
        drive(1'b0, '0, 1'b1, 1'b1, 1'b0);
        chk("R6 start", 32'(insn_start), 32'h1);
        chk("R6 no ext", 32'(ext_used), 32'h0);
        chk("R6 opcode", 32'(opcode), 32'h00B2);
        chk("R6 valid", 32'(stage_valid), 32'h6);
        chk("R10 err unchanged low", 32'(err), 32'h0);

        // R7 command beats fall-through
        do_reset();
        drive(1'b1, 16'h00C1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        chk("R7 no start", 32'(insn_start), 32'h0);
        chk("R7 ext", 32'(ext_used), 32'h1);
        chk("R7 ext word", 32'(ext_word), 32'h00C1);
        chk("R7 empty", 32'(stage_valid), 32'h0);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        chk("R7 C stays empty", 32'(stage_valid), 32'h0);

        finish_run();
    end
endmodule